// File: doc/BRIEF.md
# Memory Word Increment/Decrement Sequencer

This block adds one to, or subtracts one from, a 16-bit word that lives in byte-wide memory. It does the work as a read-modify-write through an 8-bit memory port. A single start pulse hands it an address, a direction, a code that picks one of three address spaces and the current flag byte. The sequencer then reads the two bytes of the word, computes the new value and the new flags, and writes both bytes back. It signals completion with a one-cycle done pulse and holds the new word and flags on its outputs until the next operation.

The three spaces are a plain data space and two indexed spaces, here called X and Y. The space code can be read in two ways, chosen per operation. The first is a 3-bit register code. The second is a 2-bit index code carried in the low bits of the same input. Both the address and the flags are captured when the operation is accepted. A new start pulse has no effect until the sequencer is back at rest.

Top module: `word_step_seq`

## Requirements
- R1: Every operation issues its four memory accesses in a fixed order: a read at the address, then a read at the address plus one (wrapping modulo 2^AW), then a write of the low result byte at the address, then a write of the high result byte at the address plus one. Read data appears on `mem_rdata` in the cycle after the read request.
- R2: When `code_kind` is 0, `sel_code` is a 3-bit register code: value 4 selects space X, value 5 selects space Y, and every other value selects the plain space. On `mem_space`, 0 means plain, 1 means X and 2 means Y.
- R3: When `code_kind` is 1, only `sel_code[1:0]` is used: value 0 selects space X, value 1 selects space Y, and values 2 and 3 select the plain space. Bit 2 is ignored.
- R4: When `dec` is 0, the result is the operand plus one, modulo 2^16. Flag X (bit 3) is 1 exactly when the result is 0x0000. Flag V (bit 2) is set to 1 when the operand was 0xFFFF and otherwise keeps its input value.
- R5: When `dec` is 1, the result is the operand minus one, modulo 2^16. Flag X (bit 3) is 1 exactly when the result is 0xFFFF. Flag V (bit 2) is set to 1 when the operand was 0x0000 and otherwise keeps its input value.
- R6: Flag N (bit 1) is cleared. Flag S (bit 7) equals result bit 15. Flag Z (bit 6) is 1 when the result is zero and 0 otherwise.
- R7: Flag H (bit 4), flag C (bit 0) and the unused bit 5 are passed through unchanged from `flags_in`.
- R8: Each operation makes exactly two reads and two writes. `done` is high for exactly one cycle, after the second write, with `word_out` and `flags_out` valid in that cycle.
- R9: A start pulse that arrives while an operation is in progress is ignored. It changes neither the memory traffic nor the results, and it produces no extra done pulse.
- R10: After reset, `mem_req`, `mem_we` and `done` are low, and `word_out` and `flags_out` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (taken only when at rest) |
| dec | input | 1 | 0 selects increment, 1 selects decrement |
| code_kind | input | 1 | 0 selects the register code form, 1 selects the index code form |
| sel_code | input | CODE_W | Address-space selector code |
| addr | input | AW | Address of the low byte of the word |
| flags_in | input | FLAG_W | Current flag byte |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_space | output | 2 | Space select: 0 plain, 1 X, 2 Y |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | BYTE_W | Write data |
| mem_rdata | input | BYTE_W | Read data, one cycle after the request |
| word_out | output | WORD_W | Updated word |
| flags_out | output | FLAG_W | Updated flag byte |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is a second start pulse landing while the sequencer is part-way through its access sequence. Reaching it needs a stimulus that deliberately re-asserts start in the cycle after acceptance. That second pulse carries a different address, direction, space code and flag byte. The bench then confirms that exactly four accesses were logged, that all of them use the original address and space, and that only one completion occurs. A second hard case is the high-byte address wrapping from the top of the address range to zero. It is reached by placing a word at address 0xFFFF, so the bench memory log must show the second read and second write at address zero.

// File: rtl/wstep_pkg.sv
package wstep_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_RD_LO = 3'd1,
      ST_RD_HI = 3'd2,
      ST_WR_LO = 3'd3,
      ST_WR_HI = 3'd4,
      ST_DONE  = 3'd5
   } wstep_state_e;

   localparam logic [1:0] SPC_PLAIN = 2'd0;
   localparam logic [1:0] SPC_X     = 2'd1;
   localparam logic [1:0] SPC_Y     = 2'd2;

   // flag byte bit positions
   localparam int unsigned FB_C = 0;
   localparam int unsigned FB_N = 1;
   localparam int unsigned FB_V = 2;
   localparam int unsigned FB_X = 3;
   localparam int unsigned FB_H = 4;
   localparam int unsigned FB_Z = 6;
   localparam int unsigned FB_S = 7;

endpackage

// File: rtl/wstep_space_map.sv
module wstep_space_map
   import wstep_pkg::*;
#(
   parameter int unsigned CODE_W     = 3,
   parameter int unsigned REG_X_CODE = 4,
   parameter int unsigned REG_Y_CODE = 5,
   parameter int unsigned IDX_X_CODE = 0,
   parameter int unsigned IDX_Y_CODE = 1
) (
   input  logic              code_kind,
   input  logic [CODE_W-1:0] code,
   output logic [1:0]        space
);
   localparam int unsigned REG_W = 3;
   localparam int unsigned IDX_W = 2;

   if (CODE_W < REG_W) begin : g_bad_code_w
      $error("wstep_space_map: CODE_W must be at least 3");
   end

   logic [REG_W-1:0] reg_code;
   logic [IDX_W-1:0] idx_code;

   assign reg_code = code[REG_W-1:0];
   assign idx_code = code[IDX_W-1:0];

   always_comb begin
      space = SPC_PLAIN;
      if (code_kind) begin
         if (idx_code == IDX_W'(IDX_X_CODE))      space = SPC_X;
         else if (idx_code == IDX_W'(IDX_Y_CODE)) space = SPC_Y;
      end else begin
         if (reg_code == REG_W'(REG_X_CODE))      space = SPC_X;
         else if (reg_code == REG_W'(REG_Y_CODE)) space = SPC_Y;
      end
   end

   // R2 / R3: the mapped space is never the unused code 3
   always_comb begin
      a_r2_space_legal: assert (space != 2'd3)
         else $error("space map produced an unused code");
   end

endmodule

// File: rtl/wstep_step_alu.sv
module wstep_step_alu
   import wstep_pkg::*;
#(
   parameter int unsigned BYTE_W       = 8,
   parameter int unsigned WORD_W       = 16,
   parameter int unsigned FLAG_W       = 8,
   parameter bit          SHARED_ADDER = 1'b1
) (
   input  logic              dec,
   input  logic [WORD_W-1:0] operand,
   input  logic [FLAG_W-1:0] flags_in,
   output logic [WORD_W-1:0] result,
   output logic [FLAG_W-1:0] flags_out
);
   localparam logic [WORD_W-1:0] ONE  = WORD_W'(1);
   localparam logic [WORD_W-1:0] ONES = '1;

   if (WORD_W != 2 * BYTE_W) begin : g_bad_word_w
      $error("wstep_step_alu: WORD_W must be twice BYTE_W");
   end
   if (FLAG_W != 8) begin : g_bad_flag_w
      $error("wstep_step_alu: FLAG_W must be 8");
   end

   if (SHARED_ADDER) begin : g_shared
      // one adder; decrement adds all-ones
      assign result = operand + (dec ? ONES : ONE);
   end else begin : g_split
      logic [WORD_W-1:0] up_v;
      logic [WORD_W-1:0] dn_v;
      assign up_v   = operand + ONE;
      assign dn_v   = operand - ONE;
      assign result = dec ? dn_v : up_v;
   end

   logic op_edge;
   logic res_edge;
   assign op_edge  = dec ? (operand == '0) : (operand == ONES);
   assign res_edge = dec ? (result == ONES) : (result == '0);

   always_comb begin
      flags_out       = flags_in;
      flags_out[FB_N] = 1'b0;
      flags_out[FB_S] = result[WORD_W-1];
      flags_out[FB_Z] = (result == '0);
      flags_out[FB_X] = res_edge;
      if (op_edge) flags_out[FB_V] = 1'b1;
   end

endmodule

// File: rtl/word_step_seq.sv
module word_step_seq
   import wstep_pkg::*;
#(
   parameter int unsigned AW           = 16,
   parameter int unsigned BYTE_W       = 8,
   parameter int unsigned WORD_W       = 16,
   parameter int unsigned FLAG_W       = 8,
   parameter int unsigned CODE_W       = 3,
   parameter bit          SHARED_ADDER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              dec,
   input  logic              code_kind,
   input  logic [CODE_W-1:0] sel_code,
   input  logic [AW-1:0]     addr,
   input  logic [FLAG_W-1:0] flags_in,
   output logic              mem_req,
   output logic              mem_we,
   output logic [1:0]        mem_space,
   output logic [AW-1:0]     mem_addr,
   output logic [BYTE_W-1:0] mem_wdata,
   input  logic [BYTE_W-1:0] mem_rdata,
   output logic [WORD_W-1:0] word_out,
   output logic [FLAG_W-1:0] flags_out,
   output logic              done
);
   localparam logic [AW-1:0] ADDR_STEP = AW'(1);

   if (AW < 2) begin : g_bad_aw
      $error("word_step_seq: AW must be at least 2");
   end

   wstep_state_e      state;
   logic [AW-1:0]     base_q;
   logic [1:0]        space_q;
   logic              dec_q;
   logic [FLAG_W-1:0] flg_q;
   logic [BYTE_W-1:0] lo_q;
   logic [WORD_W-1:0] res_q;
   logic [FLAG_W-1:0] fout_q;

   logic [1:0]        space_d;
   logic [WORD_W-1:0] alu_res;
   logic [FLAG_W-1:0] alu_flags;
   logic [AW-1:0]     addr_hi;
   logic              hi_phase;

   wstep_space_map #(
      .CODE_W (CODE_W)
   ) u_space (
      .code_kind (code_kind),
      .code      (sel_code),
      .space     (space_d)
   );

   // operand is formed from the high byte arriving now and the latched low byte
   wstep_step_alu #(
      .BYTE_W       (BYTE_W),
      .WORD_W       (WORD_W),
      .FLAG_W       (FLAG_W),
      .SHARED_ADDER (SHARED_ADDER)
   ) u_alu (
      .dec       (dec_q),
      .operand   ({mem_rdata, lo_q}),
      .flags_in  (flg_q),
      .result    (alu_res),
      .flags_out (alu_flags)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         base_q  <= '0;
         space_q <= SPC_PLAIN;
         dec_q   <= 1'b0;
         flg_q   <= '0;
         lo_q    <= '0;
         res_q   <= '0;
         fout_q  <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (start) begin
                  state   <= ST_RD_LO;
                  base_q  <= addr;
                  space_q <= space_d;
                  dec_q   <= dec;
                  flg_q   <= flags_in;
               end
            end
            ST_RD_LO: state <= ST_RD_HI;
            ST_RD_HI: begin
               lo_q  <= mem_rdata;
               state <= ST_WR_LO;
            end
            ST_WR_LO: begin
               res_q  <= alu_res;
               fout_q <= alu_flags;
               state  <= ST_WR_HI;
            end
            ST_WR_HI: state <= ST_DONE;
            ST_DONE:  state <= ST_IDLE;
            default:  state <= ST_IDLE;
         endcase
      end
   end

   assign addr_hi  = base_q + ADDR_STEP;
   assign hi_phase = (state == ST_RD_HI) || (state == ST_WR_HI);

   always_comb begin
      mem_req   = (state == ST_RD_LO) || (state == ST_RD_HI) ||
                  (state == ST_WR_LO) || (state == ST_WR_HI);
      mem_we    = (state == ST_WR_LO) || (state == ST_WR_HI);
      mem_addr  = hi_phase ? addr_hi : base_q;
      mem_wdata = (state == ST_WR_HI) ? res_q[WORD_W-1:BYTE_W] : alu_res[BYTE_W-1:0];
   end

   assign mem_space = space_q;
   assign word_out  = res_q;
   assign flags_out = fout_q;
   assign done      = (state == ST_DONE);

   // R1: second read of a pair targets the next byte
   a_r1_read_pair_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we && $past(mem_req && !mem_we)) |-> (mem_addr == $past(mem_addr) + ADDR_STEP));

   // R1: second write of a pair targets the next byte
   a_r1_write_pair_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + ADDR_STEP));

   // R8: writes only ever happen as requests
   a_r8_we_has_req: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> mem_req);

   // R8: completion is a single-cycle pulse
   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R2: space held steady through the access burst
   a_r2_space_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && $past(mem_req)) |-> $stable(mem_space));

   // R9: a start while busy leaves the captured operation untouched
   a_r9_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
      (start && state != ST_IDLE) |=> ($stable(base_q) && $stable(dec_q) && $stable(flg_q)));

   // R6: zero flag agrees with the delivered word
   a_r6_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (flags_out[FB_Z] == (word_out == '0)));

   // R4: increment carry-out flag agrees with the delivered word
   a_r4_inc_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !dec_q) |-> (flags_out[FB_X] == (word_out == '0)));

   // R7: untouched flags survive the operation
   a_r7_hc_kept: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (flags_out[FB_H] == flg_q[FB_H] && flags_out[FB_C] == flg_q[FB_C]));

endmodule

// File: tb/word_step_seq_bench.sv
module word_step_seq_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        start;
   logic        dec;
   logic        code_kind;
   logic [2:0]  sel_code;
   logic [15:0] addr;
   logic [7:0]  flags_in;
   logic        mem_req;
   logic        mem_we;
   logic [1:0]  mem_space;
   logic [15:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata;
   logic [15:0] word_out;
   logic [7:0]  flags_out;
   logic        done;

   always #5 clk = ~clk;

   word_step_seq u_word_step_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .dec       (dec),
      .code_kind (code_kind),
      .sel_code  (sel_code),
      .addr      (addr),
      .flags_in  (flags_in),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_space (mem_space),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata),
      .word_out  (word_out),
      .flags_out (flags_out),
      .done      (done)
   );

   int checks = 0;
   int fails  = 0;

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // memory model with access log
   logic [7:0]  mem [3][256];
   logic        pl_v;
   logic [1:0]  pl_s;
   logic [7:0]  pl_a;
   logic [7:0]  pl_d;
   logic        lg_we [256];
   logic [15:0] lg_a  [256];
   logic [1:0]  lg_s  [256];
   logic [7:0]  lg_d  [256];
   int          lg_n;

   always @(posedge clk) begin
      if (pl_v) mem[pl_s][pl_a] <= pl_d;
      if (!rst_n) begin
         lg_n      <= 0;
         mem_rdata <= 8'h00;
      end else if (mem_req) begin
         if (mem_space < 2'd3) begin
            if (mem_we) mem[mem_space][mem_addr[7:0]] <= mem_wdata;
            else        mem_rdata <= mem[mem_space][mem_addr[7:0]];
         end
         if (lg_n < 256) begin
            lg_we[lg_n] <= mem_we;
            lg_a[lg_n]  <= mem_addr;
            lg_s[lg_n]  <= mem_space;
            lg_d[lg_n]  <= mem_wdata;
         end
         lg_n <= lg_n + 1;
      end
   end

   typedef struct {
      logic [15:0] word;
      logic [7:0]  flg;
      logic [1:0]  spc;
      logic [15:0] adr;
      int          n0;
      string       rq_op;
      string       rq_sp;
   } exp_t;

   exp_t sbq[$];

   function automatic logic [1:0] ref_space(input logic kind, input logic [2:0] code);
      if (kind) begin
         if (code[1:0] == 2'd0) return 2'd1;
         if (code[1:0] == 2'd1) return 2'd2;
         return 2'd0;
      end
      if (code == 3'd4) return 2'd1;
      if (code == 3'd5) return 2'd2;
      return 2'd0;
   endfunction

   function automatic logic [23:0] ref_step(input logic d, input logic [15:0] w,
                                            input logic [7:0] f);
      logic [15:0] r;
      logic [7:0]  fo;
      r = d ? (w - 16'd1) : (w + 16'd1);
      fo    = f;
      fo[1] = 1'b0;
      fo[7] = r[15];
      fo[6] = (r == 16'h0000);
      fo[3] = d ? (w == 16'h0000) : (w == 16'hFFFF);
      if (d ? (w == 16'h0000) : (w == 16'hFFFF)) fo[2] = 1'b1;
      return {r, fo};
   endfunction

   task automatic preload(input logic [1:0] s, input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      pl_v = 1'b1; pl_s = s; pl_a = a; pl_d = d;
      @(negedge clk);
      pl_v = 1'b0;
   endtask

   task automatic run_op(input logic d, input logic kind, input logic [2:0] code,
                         input logic [15:0] a, input logic [15:0] w,
                         input logic [7:0] f, input bit poke);
      logic [1:0]  s;
      logic [15:0] a1;
      logic [23:0] rr;
      exp_t        e;
      s  = ref_space(kind, code);
      a1 = a + 16'd1;
      preload(s, a[7:0], w[7:0]);
      preload(s, a1[7:0], w[15:8]);
      rr = ref_step(d, w, f);
      e.word  = rr[23:8];
      e.flg   = rr[7:0];
      e.spc   = s;
      e.adr   = a;
      e.rq_op = d ? "R5" : "R4";
      e.rq_sp = kind ? "R3" : "R2";
      @(negedge clk);
      e.n0 = lg_n;
      sbq.push_back(e);
      start = 1'b1; dec = d; code_kind = kind; sel_code = code; addr = a; flags_in = f;
      @(negedge clk);
      start = 1'b0;
      if (poke) begin
         // R9: second pulse with different arguments while busy
         start = 1'b1; dec = ~d; code_kind = ~kind; sel_code = code ^ 3'b001;
         addr = a + 16'd5; flags_in = ~f;
         @(negedge clk);
         start = 1'b0;
      end
      while (sbq.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (sbq.size() == 0) begin
            chk("R9", "unexpected done", 32'd1, 32'd0);
         end else begin
            exp_t e;
            logic [15:0] a1;
            e  = sbq.pop_front();
            a1 = e.adr + 16'd1;
            chk(e.rq_op, "word_out", word_out, e.word);
            chk(e.rq_op, "flags X,V", flags_out & 8'h0C, e.flg & 8'h0C);
            chk("R6", "flags S,Z,N", flags_out & 8'hC2, e.flg & 8'hC2);
            chk("R7", "flags H,C,b5", flags_out & 8'h31, e.flg & 8'h31);
            chk("R8", "access count", lg_n - e.n0, 4);
            chk("R1", "access order we", {lg_we[e.n0], lg_we[e.n0+1], lg_we[e.n0+2], lg_we[e.n0+3]}, 4'b0011);
            chk("R1", "rd lo addr", lg_a[e.n0], e.adr);
            chk("R1", "rd hi addr", lg_a[e.n0+1], a1);
            chk("R1", "wr lo addr", lg_a[e.n0+2], e.adr);
            chk("R1", "wr hi addr", lg_a[e.n0+3], a1);
            chk("R1", "wr lo data", lg_d[e.n0+2], e.word[7:0]);
            chk("R1", "wr hi data", lg_d[e.n0+3], e.word[15:8]);
            chk(e.rq_sp, "space", {lg_s[e.n0], lg_s[e.n0+1], lg_s[e.n0+2], lg_s[e.n0+3]},
                {e.spc, e.spc, e.spc, e.spc});
            chk("R1", "mem hi byte", mem[e.spc][a1[7:0]], e.word[15:8]);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      rst_n = 1'b0; start = 1'b0; dec = 1'b0; code_kind = 1'b0; sel_code = 3'd0;
      addr = 16'h0; flags_in = 8'h0; pl_v = 1'b0; pl_s = 2'd0; pl_a = 8'd0; pl_d = 8'd0;
      repeat (3) @(negedge clk);
      // R10: reset state
      chk("R10", "mem_req", mem_req, 0);
      chk("R10", "mem_we", mem_we, 0);
      chk("R10", "done", done, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10", "word_out", word_out, 0);
      chk("R10", "flags_out", flags_out, 0);

      run_op(1'b0, 1'b0, 3'd0, 16'h0040, 16'h1234, 8'h00, 1'b0); // R4 plain
      run_op(1'b0, 1'b0, 3'd4, 16'h0050, 16'hFFFF, 8'h00, 1'b0); // R4 wrap, R2 X
      run_op(1'b0, 1'b0, 3'd5, 16'h0060, 16'h7FFF, 8'hFF, 1'b0); // R6 S, R7 keep, R2 Y
      run_op(1'b1, 1'b0, 3'd7, 16'h0070, 16'h0000, 8'h00, 1'b0); // R5 wrap
      run_op(1'b1, 1'b1, 3'd0, 16'h0080, 16'h0001, 8'h20, 1'b0); // R5 zero, R3 X
      run_op(1'b1, 1'b1, 3'd5, 16'h0090, 16'h8000, 8'h11, 1'b0); // R3 bit2 ignored -> Y
      run_op(1'b0, 1'b1, 3'd2, 16'h00A0, 16'h00FF, 8'h04, 1'b0); // R3 plain, V kept
      run_op(1'b0, 1'b1, 3'd3, 16'h00A4, 16'h8FFF, 8'h0A, 1'b0); // R3 plain
      run_op(1'b1, 1'b0, 3'd3, 16'h00B0, 16'h1000, 8'hFE, 1'b0); // R2 code 3 plain
      run_op(1'b0, 1'b1, 3'd4, 16'h00B4, 16'h0102, 8'h00, 1'b0); // R3 code 4 -> X
      run_op(1'b0, 1'b0, 3'd0, 16'hFFFF, 16'hABCD, 8'h00, 1'b0); // R1 address wrap
      run_op(1'b1, 1'b0, 3'd5, 16'h00C0, 16'h1000, 8'h00, 1'b1); // R9 busy start
      run_op(1'b0, 1'b1, 3'd1, 16'h00C8, 16'hFFFF, 8'h10, 1'b1); // R9 again
      // R9: no further completion after the poked operations
      repeat (10) begin
         @(negedge clk);
         chk("R9", "idle done", done, 0);
      end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule